// File: doc/BRIEF.md
# Receive Misaligned-Frame Error Counter

This block counts received frames that are corrupt in a particular way: the frame check sequence did not match, and the number of bits in the frame is not a whole number of octets. It sits beside a receive path. At the end of each frame, that path presents a one-cycle strobe together with an FCS-error flag and the frame length in bits. Only frames that carry both faults move the count. The block has no transmit-side input, so transmit activity cannot change it.

Software sees the count as the low 16 bits of a 32-bit register. The upper bits always read as zero. The register port has byte enables and a 2-bit write operation code, which selects a plain store or a set, clear or toggle of chosen bits. A read returns the count and then zeroes it, so that software gathers the number of such frames seen since its last read. A read with the two low byte enables both off only looks at the count and leaves it as it is.

Top module: `rx_misalign_stat`

## Requirements
- R1: The count is 16 bits wide and is read in bits 15:0 of `reg_rdata`. Bits 31:16 of `reg_rdata` are always zero, and write data or byte enables for bytes 2 and 3 never change anything.
- R2: After reset, the count is zero and `reg_rdata` is zero.
- R3: When `frm_eof` is high with `frm_fcs_bad` high and `frm_bits[2:0]` not equal to 000, the count rises by one in the following cycle.
- R4: The count does not change for an FCS error with `frm_bits[2:0]` = 000, for a good FCS at any length, or when `frm_fcs_bad` is high without `frm_eof`.
- R5: A qualifying frame that arrives while the count is 0xFFFF leaves it at 0xFFFF.
- R6: A read (`reg_rd` high) returns the count on `reg_rdata` one cycle later. The value returned is the count from before any clear. The read zeroes the count unless `reg_be[1:0]` = 00, in which case the count is left unchanged.
- R7: A clearing read and a qualifying frame in the same cycle leave a count of 1.
- R8: A write (`reg_wr` high) acts on each byte whose enable is set: byte 0 on bits 7:0 and byte 1 on bits 15:8. `reg_op` selects the action: 00 stores the data, 01 ORs it in, 10 clears the bits set in the data, and 11 XORs it. Bytes whose enable is off keep their value.
- R9: A write that enables byte 0 or byte 1 takes priority over a qualifying frame in the same cycle, and that frame is not counted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frm_eof | input | 1 | End-of-frame strobe from the receive path |
| frm_fcs_bad | input | 1 | FCS check failed for the ending frame |
| frm_bits | input | 14 | Length of the ending frame in bits |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_op | input | 2 | Write action: 00 store, 01 set, 10 clear, 11 toggle |
| reg_be | input | 4 | Byte enables |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid one cycle after `reg_rd` |

## Verification
The counting event can land in the same cycle as a software access, either a clearing read or a write. The bench drives the frame strobe together with `reg_rd` and with `reg_wr`. For the read, it expects the returned data to show the count from before the clear and the count left afterwards to be exactly 1. For the write, it expects the written value to stand with nothing added. The bench also pairs a frame strobe with a non-clearing read and with a write whose low byte enables are both off, and in both cases the frame must still be counted.

// File: rtl/rxal_pkg.sv
package rxal_pkg;

  typedef enum logic [1:0] {
    ALIAS_STORE  = 2'b00,
    ALIAS_SET    = 2'b01,
    ALIAS_CLR    = 2'b10,
    ALIAS_TOGGLE = 2'b11
  } alias_e;

  // Result of one write action on a single byte of the count.
  function automatic logic [7:0] alias_byte(alias_e op, logic [7:0] cur, logic [7:0] dat);
    logic [7:0] res;
    case (op)
      ALIAS_STORE:  res = dat;
      ALIAS_SET:    res = cur | dat;
      ALIAS_CLR:    res = cur & ~dat;
      ALIAS_TOGGLE: res = cur ^ dat;
      default:      res = cur;
    endcase
    return res;
  endfunction

endpackage

// File: rtl/rxal_frame_qual.sv
module rxal_frame_qual (
  input  logic       eof,
  input  logic       fcs_bad,
  input  logic [2:0] bit_rem,
  output logic       hit
);
  logic misaligned;

  always_comb begin
    misaligned = |bit_rem;
    hit        = eof & fcs_bad & misaligned;
  end
endmodule

// File: rtl/rxal_wr_merge.sv
module rxal_wr_merge
  import rxal_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                 wr,
  input  alias_e               op,
  input  logic [CNT_W/8-1:0]   be,
  input  logic [CNT_W-1:0]     wdata,
  input  logic [CNT_W-1:0]     cur,
  output logic                 take,
  output logic [CNT_W-1:0]     val
);
  localparam int NBYTES = CNT_W / 8;

  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    always_comb begin
      if (be[b]) begin
        val[8*b +: 8] = alias_byte(op, cur[8*b +: 8], wdata[8*b +: 8]);
      end else begin
        val[8*b +: 8] = cur[8*b +: 8];
      end
    end
  end

  always_comb begin
    take = wr & (|be);
  end
endmodule

// File: rtl/rxal_count_reg.sv
module rxal_count_reg #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_take,
  input  logic [CNT_W-1:0] wr_val,
  input  logic             rd_clr,
  input  logic             hit,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  // Priority: software write, then clear-on-read (keeping a coincident event), then count.
  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (wr_take) begin
      cnt_d  = wr_val;
      cnt_en = 1'b1;
    end else if (rd_clr) begin
      cnt_d  = hit ? CNT_ONE : '0;
      cnt_en = 1'b1;
    end else if (hit && (cnt_q != CNT_MAX)) begin
      cnt_d  = cnt_q + CNT_ONE;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/rxal_rd_port.sv
module rxal_rd_port #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd,
  input  logic [CNT_W-1:0]  cnt,
  output logic [DATA_W-1:0] rdata
);
  localparam int PAD_W = DATA_W - CNT_W;

  logic [DATA_W-1:0] rdata_q;
  logic [DATA_W-1:0] rdata_d;

  always_comb begin
    rdata_d = {{PAD_W{1'b0}}, cnt};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (rd) begin
      rdata_q <= rdata_d;
    end
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/rx_misalign_stat.sv
module rx_misalign_stat
  import rxal_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32,
  parameter int LEN_W  = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frm_eof,
  input  logic              frm_fcs_bad,
  input  logic [LEN_W-1:0]  frm_bits,
  input  logic              reg_rd,
  input  logic              reg_wr,
  input  logic [1:0]        reg_op,
  input  logic [DATA_W/8-1:0] reg_be,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata
);
  localparam int CNT_BYTES = CNT_W / 8;

  logic                 hit;
  logic                 wr_take;
  logic [CNT_W-1:0]     wr_val;
  logic [CNT_W-1:0]     cnt_q;
  logic                 rd_clr;
  alias_e               op_e;
  logic                 unused_hi;

  assign op_e      = alias_e'(reg_op);
  assign rd_clr    = reg_rd & (|reg_be[CNT_BYTES-1:0]);
  assign unused_hi = ^{reg_wdata[DATA_W-1:CNT_W], reg_be[DATA_W/8-1:CNT_BYTES],
                       frm_bits[LEN_W-1:3]};

  rxal_frame_qual u_qual (
    .eof     (frm_eof),
    .fcs_bad (frm_fcs_bad),
    .bit_rem (frm_bits[2:0]),
    .hit     (hit)
  );

  rxal_wr_merge #(.CNT_W(CNT_W)) u_merge (
    .wr    (reg_wr),
    .op    (op_e),
    .be    (reg_be[CNT_BYTES-1:0]),
    .wdata (reg_wdata[CNT_W-1:0]),
    .cur   (cnt_q),
    .take  (wr_take),
    .val   (wr_val)
  );

  rxal_count_reg #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_take (wr_take),
    .wr_val  (wr_val),
    .rd_clr  (rd_clr),
    .hit     (hit),
    .cnt     (cnt_q)
  );

  rxal_rd_port #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_rd (
    .clk   (clk),
    .rst_n (rst_n),
    .rd    (reg_rd),
    .cnt   (cnt_q),
    .rdata (reg_rdata)
  );
endmodule

// File: rtl/rxal_check.sv
module rxal_check #(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32,
  parameter int LEN_W  = 14
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frm_eof,
  input logic              frm_fcs_bad,
  input logic [LEN_W-1:0]  frm_bits,
  input logic              reg_rd,
  input logic              reg_wr,
  input logic [DATA_W/8-1:0] reg_be,
  input logic [DATA_W-1:0] reg_rdata,
  input logic [CNT_W-1:0]  cnt
);
  localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};
  localparam int CB = CNT_W / 8;

  logic qual;
  logic sw_touch;
  assign qual     = frm_eof && frm_fcs_bad && (frm_bits[2:0] != 3'b000);
  assign sw_touch = (reg_wr && (|reg_be[CB-1:0])) || (reg_rd && (|reg_be[CB-1:0]));

  a_r1_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[DATA_W-1:CNT_W] == '0);

  a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
    (qual && !sw_touch && cnt != MAXV) |=> cnt == $past(cnt) + 1'b1);

  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!qual && !sw_touch) |=> $stable(cnt));

  a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (qual && !sw_touch && cnt == MAXV) |=> cnt == MAXV);

  a_r6_rd_value: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> reg_rdata[CNT_W-1:0] == $past(cnt));

  a_r6_rd_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && !reg_wr && (|reg_be[CB-1:0]) && !qual) |=> cnt == '0);

  a_r7_clear_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && !reg_wr && (|reg_be[CB-1:0]) && qual) |=> cnt == CNT_W'(1));
endmodule

bind rx_misalign_stat rxal_check #(.CNT_W(CNT_W), .DATA_W(DATA_W), .LEN_W(LEN_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .frm_eof     (frm_eof),
  .frm_fcs_bad (frm_fcs_bad),
  .frm_bits    (frm_bits),
  .reg_rd      (reg_rd),
  .reg_wr      (reg_wr),
  .reg_be      (reg_be),
  .reg_rdata   (reg_rdata),
  .cnt         (cnt_q)
);

// File: tb/sim_rx_misalign_stat.sv
module sim_rx_misalign_stat;
  localparam int CLK_PERIOD = 10;
  localparam int WD_LIMIT   = 100000;

  logic        clk;
  logic        rst_n;
  logic        frm_eof;
  logic        frm_fcs_bad;
  logic [13:0] frm_bits;
  logic        reg_rd;
  logic        reg_wr;
  logic [1:0]  reg_op;
  logic [3:0]  reg_be;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;

  int total;
  int bad;
  int cycles;
  bit finished;
  logic [15:0] model;

  rx_misalign_stat u0 (
    .clk(clk), .rst_n(rst_n), .frm_eof(frm_eof), .frm_fcs_bad(frm_fcs_bad),
    .frm_bits(frm_bits), .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_op(reg_op),
    .reg_be(reg_be), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    frm_eof = 0; frm_fcs_bad = 0; frm_bits = '0;
    reg_rd = 0; reg_wr = 0; reg_op = 2'b00; reg_be = 4'h0; reg_wdata = '0;
  endtask

  // Apply one cycle of stimulus starting at a falling edge.
  task automatic drive(logic rd, logic wr, logic [1:0] op, logic [3:0] be, logic [31:0] wd,
                       logic eof, logic fb, logic [13:0] bits);
    reg_rd = rd; reg_wr = wr; reg_op = op; reg_be = be; reg_wdata = wd;
    frm_eof = eof; frm_fcs_bad = fb; frm_bits = bits;
    @(negedge clk);
    idle_inputs();
  endtask

  // Non-clearing read; returns the count.
  task automatic peek(output logic [31:0] v);
    drive(1, 0, 2'b00, 4'h0, '0, 0, 0, '0);
    v = reg_rdata;
  endtask

  function automatic logic [7:0] ref_byte(logic [1:0] op, logic [7:0] c, logic [7:0] d);
    case (op)
      2'b00: return d;
      2'b01: return c | d;
      2'b10: return c & ~d;
      default: return c ^ d;
    endcase
  endfunction

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    cycles = 0;
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > WD_LIMIT) begin
        total++; bad++;
        $display("FAIL watchdog actual=%0d expected<%0d", cycles, WD_LIMIT);
        finish_run();
      end
    end
  end

  initial begin
    logic [31:0] v;
    total = 0; bad = 0; finished = 0;
    idle_inputs();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R2: reset state
    check("R2 rdata after reset", reg_rdata, 32'h0);
    peek(v);
    check("R2 count after reset", v, 32'h0);

    // R3/R4: sweep lengths and FCS flag
    model = 0;
    for (int fb = 0; fb < 2; fb++) begin
      for (int len = 0; len < 64; len++) begin
        drive(0, 0, 2'b00, 4'h0, '0, 1, fb[0], 14'(len + 1000));
        if (fb == 1 && ((len + 1000) % 8) != 0) model++;
        peek(v);
        check((fb == 1 && (len % 8) != 0) ? "R3 misaligned bad FCS" : "R4 no count", v, {16'h0, model});
      end
    end
    // R4: FCS flag without end-of-frame strobe
    drive(0, 0, 2'b00, 4'h0, '0, 0, 1, 14'd13);
    peek(v);
    check("R4 no strobe", v, {16'h0, model});

    // R3: frame counted alongside a non-clearing read and a write with low enables off
    drive(1, 0, 2'b00, 4'h0, '0, 1, 1, 14'd9);
    model++;
    peek(v);
    check("R3 with plain read", v, {16'h0, model});
    drive(0, 1, 2'b00, 4'hC, 32'hFFFF_FFFF, 1, 1, 14'd9);
    model++;
    peek(v);
    check("R1 R3 write upper bytes only", v, {16'h0, model});

    // R6: clearing read returns old value, then zero
    drive(1, 0, 2'b00, 4'h1, '0, 0, 0, '0);
    check("R6 read value", reg_rdata, {16'h0, model});
    peek(v);
    check("R6 cleared", v, 32'h0);

    // R1/R8: full store; upper read zero
    drive(0, 1, 2'b00, 4'hF, 32'h1234_ABCD, 0, 0, '0);
    peek(v);
    check("R1 R8 store", v, 32'h0000_ABCD);

    // R8: op x byte-enable sweep
    for (int op = 0; op < 4; op++) begin
      for (int be = 0; be < 16; be++) begin
        logic [15:0] e;
        drive(0, 1, 2'b00, 4'h3, 32'h0000_5A3C, 0, 0, '0);
        drive(0, 1, 2'(op), 4'(be), 32'hC3C3_0FF0, 0, 0, '0);
        e[7:0]  = be[0] ? ref_byte(2'(op), 8'h3C, 8'hF0) : 8'h3C;
        e[15:8] = be[1] ? ref_byte(2'(op), 8'h5A, 8'h0F) : 8'h5A;
        peek(v);
        check("R8 alias sweep", v, {16'h0, e});
      end
    end

    // R5: saturation
    drive(0, 1, 2'b00, 4'h3, 32'h0000_FFFE, 0, 0, '0);
    drive(0, 0, 2'b00, 4'h0, '0, 1, 1, 14'd3);
    peek(v);
    check("R5 reach max", v, 32'h0000_FFFF);
    drive(0, 0, 2'b00, 4'h0, '0, 1, 1, 14'd5);
    peek(v);
    check("R5 hold at max", v, 32'h0000_FFFF);

    // R7: clearing read and frame together
    drive(1, 0, 2'b00, 4'h2, '0, 1, 1, 14'd13);
    check("R7 read returns pre-clear", reg_rdata, 32'h0000_FFFF);
    peek(v);
    check("R7 count is one", v, 32'h1);

    // R9: write and frame together
    drive(0, 1, 2'b00, 4'h3, 32'h0000_0050, 1, 1, 14'd13);
    peek(v);
    check("R9 write wins", v, 32'h0000_0050);

    finish_run();
  end
endmodule